// File: doc/BRIEF.md
# Pattern Recalculation Trigger Controller

This block sits beside a compressed sharing-pattern table in a coherence directory. When an eviction update arrives, it receives the sharing pattern that the affected bucket currently points to. With that pattern come a flag that says whether the pattern was formed by OR-ing more than one pattern into the table entry, the entry's reference count and a policy select. From these inputs the block decides whether the possibly polluted pattern should be cleaned.

When it decides to clean, it issues a one-cycle multicast request. The request addresses every sharer in the pattern except the evicting core. The block then collects one presence bit from each addressed core. Once all of them have answered, it emits the exact pattern for reinsertion. That pattern contains only the cores that reported presence, so cores whose bits came only from merging drop out.

Only one recalculation can be in flight at a time. Eviction updates that arrive while one is in flight pass through without a recalculation. The network that carries requests and responses is outside this block.

Top module: `recalc_trigger_ctrl`

## Requirements
- R1: After reset, `req_valid`, `rebuilt_valid` and `busy` are low.
- R2: An eviction update whose pollution flag is low never produces a request.
- R3: With `policy_sel` = 0 (every), each qualifying eviction produces a request. A qualifying eviction is valid, polluted and arrives while the block is idle.
- R4: With `policy_sel` = 1 (every third), only the third, sixth, ninth and later qualifying evictions produce a request. The modulo-3 counter advances only on qualifying evictions while this policy is selected.
- R5: With `policy_sel` = 2 (reference count), a request is produced only when `evict_refcnt` is at least REF_THRESH (48 by default).
- R6: With `policy_sel` = 3 (sharer count), a request is produced only when the pattern holds more than SHARER_THRESH (4 by default) set bits.
- R7: A request is a one-cycle `req_valid` pulse in the cycle after the eviction is presented. Its `req_mask` is the pattern with bit `evict_core` cleared. If that mask is empty, no request is made.
- R8: While `busy` is high, eviction updates produce no request and do not advance the every-third counter.
- R9: A response is ignored if it comes from a core not still pending, if it repeats a core that has already answered, or if it arrives while the block is idle.
- R10: `rebuilt_valid` pulses for one cycle in the cycle after the last pending response is presented. `rebuilt_pattern` then holds exactly the addressed cores that answered with presence 1, and `busy` falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evict_valid | input | 1 | Eviction update present |
| evict_core | input | CORE_W | Index of the evicting core |
| evict_pattern | input | NUM_CORES | Current pattern of the bucket |
| evict_polluted | input | 1 | Table entry has had several patterns merged in |
| evict_refcnt | input | REFCNT_W | Number of buckets pointing at the entry |
| policy_sel | input | 2 | 0 every, 1 every third, 2 reference count, 3 sharer count |
| rsp_valid | input | 1 | Response present |
| rsp_core | input | CORE_W | Responding core |
| rsp_present | input | 1 | Responder still holds a block in the bucket |
| req_valid | output | 1 | Multicast request pulse |
| req_mask | output | NUM_CORES | Cores addressed by the request |
| rebuilt_valid | output | 1 | Rebuilt pattern ready |
| rebuilt_pattern | output | NUM_CORES | Exact pattern for reinsertion |
| busy | output | 1 | Recalculation outstanding |

## Verification
A request is due one clock after its eviction is presented. The rebuilt pattern is due one clock after the final pending response is presented. `busy` rises with the request and falls with the rebuilt pulse. The bench presents stimulus just after a falling edge and advances a behavioural model at each rising edge. It then compares every output against that model at the next falling edge, so each expected value is sampled exactly one register stage after its cause. Mask and pattern values are compared only in cycles where their valid pulse is expected.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [1:0] {
    POL_EVERY   = 2'd0,
    POL_THIRD   = 2'd1,
    POL_REFCNT  = 2'd2,
    POL_SHARERS = 2'd3
  } policy_e;
endpackage

// File: rtl/rtc_popcount.sv
module rtc_popcount #(
  parameter int W  = 16,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  bits_i,
  output logic [CW-1:0] count_o
);
  logic [CW-1:0] psum [W+1];
  assign psum[0] = '0;
  for (genvar g = 0; g < W; g++) begin : g_acc
    assign psum[g+1] = psum[g] + CW'(bits_i[g]);
  end
  assign count_o = psum[W];
endmodule

// File: rtl/rtc_policy_gate.sv
module rtc_policy_gate
  import rtc_pkg::*;
#(
  parameter int NUM_CORES     = 16,
  parameter int REFCNT_W      = 8,
  parameter int REF_THRESH    = 48,
  parameter int SHARER_THRESH = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 qual_i,
  input  policy_e              policy_i,
  input  logic [REFCNT_W-1:0]  refcnt_i,
  input  logic [NUM_CORES-1:0] pattern_i,
  output logic                 fire_o
);
  localparam int CNT_W = $clog2(NUM_CORES + 1);

  logic [CNT_W-1:0] sharers;
  logic [1:0]       third_q, third_n;
  logic             third_en;

  rtc_popcount #(.W(NUM_CORES), .CW(CNT_W)) u_pop (
    .bits_i  (pattern_i),
    .count_o (sharers)
  );

  assign third_en = qual_i && (policy_i == POL_THIRD);

  always_comb begin
    third_n = (third_q == 2'd2) ? 2'd0 : third_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        third_q <= 2'd0;
    else if (third_en) third_q <= third_n;
  end

  always_comb begin
    unique case (policy_i)
      POL_EVERY:   fire_o = qual_i;
      POL_THIRD:   fire_o = qual_i && (third_q == 2'd2);
      POL_REFCNT:  fire_o = qual_i && (refcnt_i >= REFCNT_W'(REF_THRESH));
      POL_SHARERS: fire_o = qual_i && (sharers > CNT_W'(SHARER_THRESH));
      default:     fire_o = 1'b0;
    endcase
  end

  // R4: the third-eviction counter moves only on qualifying evictions
  assert_third_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !third_en |=> $stable(third_q));
endmodule

// File: rtl/rtc_collector.sv
module rtc_collector #(
  parameter int NUM_CORES = 16,
  parameter int CORE_W    = $clog2(NUM_CORES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [NUM_CORES-1:0] start_mask_i,
  input  logic                 rsp_valid_i,
  input  logic [CORE_W-1:0]    rsp_core_i,
  input  logic                 rsp_present_i,
  output logic                 busy_o,
  output logic                 req_valid_o,
  output logic [NUM_CORES-1:0] req_mask_o,
  output logic                 rebuilt_valid_o,
  output logic [NUM_CORES-1:0] rebuilt_pattern_o
);
  logic                 busy_q, busy_n;
  logic [NUM_CORES-1:0] pend_q, pend_n;
  logic [NUM_CORES-1:0] acc_q, acc_n;
  logic                 req_q, req_n;
  logic [NUM_CORES-1:0] mask_q;
  logic                 rb_q, rb_n;
  logic [NUM_CORES-1:0] rb_pat_q;
  logic [NUM_CORES-1:0] rsp_oh;
  logic                 hit, done, start_ok;

  assign rsp_oh   = NUM_CORES'(1) << rsp_core_i;
  assign hit      = busy_q && rsp_valid_i && (|(pend_q & rsp_oh));
  assign start_ok = start_i && !busy_q;

  always_comb begin
    pend_n = pend_q;
    acc_n  = acc_q;
    busy_n = busy_q;
    req_n  = 1'b0;
    done   = 1'b0;
    if (start_ok) begin
      pend_n = start_mask_i;
      acc_n  = '0;
      busy_n = 1'b1;
      req_n  = 1'b1;
    end else if (hit) begin
      pend_n = pend_q & ~rsp_oh;
      if (rsp_present_i) acc_n = acc_q | rsp_oh;
      if (pend_n == '0) begin
        done   = 1'b1;
        busy_n = 1'b0;
      end
    end
    rb_n = done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pend_q <= '0;
      acc_q  <= '0;
      req_q  <= 1'b0;
      rb_q   <= 1'b0;
    end else begin
      busy_q <= busy_n;
      pend_q <= pend_n;
      acc_q  <= acc_n;
      req_q  <= req_n;
      rb_q   <= rb_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mask_q <= '0;
    else if (start_ok) mask_q <= start_mask_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rb_pat_q <= '0;
    else if (done) rb_pat_q <= acc_n;
  end

  assign busy_o            = busy_q;
  assign req_valid_o       = req_q;
  assign req_mask_o        = mask_q;
  assign rebuilt_valid_o   = rb_q;
  assign rebuilt_pattern_o = rb_pat_q;

  // R8: a request only leaves an idle controller
  assert_req_from_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> !$past(busy_q));
  // R10: rebuilt pattern never names a core outside the request
  assert_rebuilt_subset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rb_q |-> ((rb_pat_q & ~mask_q) == '0));
  // R10: rebuilt pulse closes an outstanding recalculation
  assert_rebuilt_after_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rb_q |-> ($past(busy_q) && !busy_q));
  // R9: without a response the outstanding state persists
  assert_wait_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !rsp_valid_i) |=> (busy_q && $stable(pend_q)));
endmodule

// File: rtl/recalc_trigger_ctrl.sv
module recalc_trigger_ctrl
  import rtc_pkg::*;
#(
  parameter int NUM_CORES     = 16,
  parameter int CORE_W        = $clog2(NUM_CORES),
  parameter int REFCNT_W      = 8,
  parameter int REF_THRESH    = 48,
  parameter int SHARER_THRESH = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 evict_valid,
  input  logic [CORE_W-1:0]    evict_core,
  input  logic [NUM_CORES-1:0] evict_pattern,
  input  logic                 evict_polluted,
  input  logic [REFCNT_W-1:0]  evict_refcnt,
  input  logic [1:0]           policy_sel,
  input  logic                 rsp_valid,
  input  logic [CORE_W-1:0]    rsp_core,
  input  logic                 rsp_present,
  output logic                 req_valid,
  output logic [NUM_CORES-1:0] req_mask,
  output logic                 rebuilt_valid,
  output logic [NUM_CORES-1:0] rebuilt_pattern,
  output logic                 busy
);
  logic                 qual, fire, start;
  logic [NUM_CORES-1:0] core_oh, target;

  assign core_oh = NUM_CORES'(1) << evict_core;
  assign target  = evict_pattern & ~core_oh;
  assign qual    = evict_valid && evict_polluted && !busy;
  assign start   = fire && (target != '0);

  rtc_policy_gate #(
    .NUM_CORES(NUM_CORES), .REFCNT_W(REFCNT_W),
    .REF_THRESH(REF_THRESH), .SHARER_THRESH(SHARER_THRESH)
  ) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .qual_i    (qual),
    .policy_i  (policy_e'(policy_sel)),
    .refcnt_i  (evict_refcnt),
    .pattern_i (evict_pattern),
    .fire_o    (fire)
  );

  rtc_collector #(.NUM_CORES(NUM_CORES), .CORE_W(CORE_W)) u_coll (
    .clk               (clk),
    .rst_n             (rst_n),
    .start_i           (start),
    .start_mask_i      (target),
    .rsp_valid_i       (rsp_valid),
    .rsp_core_i        (rsp_core),
    .rsp_present_i     (rsp_present),
    .busy_o            (busy),
    .req_valid_o       (req_valid),
    .req_mask_o        (req_mask),
    .rebuilt_valid_o   (rebuilt_valid),
    .rebuilt_pattern_o (rebuilt_pattern)
  );

  // R2: an unpolluted update is never followed by a request
  assert_unpolluted_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evict_valid && !evict_polluted) |=> !req_valid);
  // R7: request names only other sharers of the presented pattern
  assert_req_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (((req_mask & ~$past(evict_pattern)) == '0)
                   && ((req_mask & $past(core_oh)) == '0)));
  // R7: a request always addresses at least one core
  assert_req_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_mask != '0));
endmodule

// File: tb/recalc_trigger_ctrl_tb.sv
module recalc_trigger_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evict_valid = 1'b0;
  logic [3:0] evict_core = '0;
  logic [NC-1:0] evict_pattern = '0;
  logic evict_polluted = 1'b0;
  logic [7:0] evict_refcnt = '0;
  logic [1:0] policy_sel = '0;
  logic rsp_valid = 1'b0;
  logic [3:0] rsp_core = '0;
  logic rsp_present = 1'b0;
  logic req_valid, rebuilt_valid, busy;
  logic [NC-1:0] req_mask, rebuilt_pattern;

  int n_cmp = 0;
  int n_bad = 0;
  string tag = "R1";

  // behavioural reference state
  bit m_busy;
  bit [NC-1:0] m_pend, m_acc;
  int m_third;
  bit e_req, e_rb;
  bit [NC-1:0] e_mask, e_pat;

  always #(CLK_PERIOD/2) clk = ~clk;

  recalc_trigger_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .evict_valid(evict_valid), .evict_core(evict_core),
    .evict_pattern(evict_pattern), .evict_polluted(evict_polluted),
    .evict_refcnt(evict_refcnt), .policy_sel(policy_sel), .rsp_valid(rsp_valid),
    .rsp_core(rsp_core), .rsp_present(rsp_present), .req_valid(req_valid),
    .req_mask(req_mask), .rebuilt_valid(rebuilt_valid),
    .rebuilt_pattern(rebuilt_pattern), .busy(busy));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_pend = '0; m_acc = '0; m_third = 0;
      e_req = 0; e_rb = 0; e_mask = '0; e_pat = '0;
    end else begin
      e_req = 0;
      e_rb  = 0;
      if (m_busy) begin
        if (rsp_valid && m_pend[rsp_core]) begin
          m_pend[rsp_core] = 1'b0;
          if (rsp_present) m_acc[rsp_core] = 1'b1;
          if (m_pend == '0) begin
            e_rb = 1; e_pat = m_acc; m_busy = 0;
          end
        end
      end else if (evict_valid && evict_polluted) begin
        bit [NC-1:0] tgt;
        bit go;
        tgt = evict_pattern;
        tgt[evict_core] = 1'b0;
        case (policy_sel)
          2'd0: go = 1;
          2'd1: begin go = (m_third == 2); m_third = (m_third + 1) % 3; end
          2'd2: go = (evict_refcnt >= 48);
          default: go = ($countones(evict_pattern) > 4);
        endcase
        if (go && tgt != '0) begin
          e_req = 1; e_mask = tgt; m_pend = tgt; m_acc = '0; m_busy = 1;
        end
      end
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk("busy", 32'(busy), 32'(m_busy));
    chk("req_valid", 32'(req_valid), 32'(e_req));
    chk("rebuilt_valid", 32'(rebuilt_valid), 32'(e_rb));
    if (e_req) chk("req_mask", 32'(req_mask), 32'(e_mask));
    if (e_rb)  chk("rebuilt_pattern", 32'(rebuilt_pattern), 32'(e_pat));
  endtask

  task automatic evict(int core, bit [NC-1:0] pat, bit pol, int rc);
    evict_valid = 1; evict_core = 4'(core); evict_pattern = pat;
    evict_polluted = pol; evict_refcnt = 8'(rc);
    tick();
    evict_valid = 0;
  endtask

  task automatic respond(int core, bit pres);
    rsp_valid = 1; rsp_core = 4'(core); rsp_present = pres;
    tick();
    rsp_valid = 0;
  endtask

  task automatic serve(bit [NC-1:0] mask, bit [NC-1:0] pres);
    for (int i = 0; i < NC; i++) if (mask[i]) respond(i, pres[i]);
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    tag = "R1";
    chk("reset busy", 32'(busy), 0);
    chk("reset req_valid", 32'(req_valid), 0);
    chk("reset rebuilt_valid", 32'(rebuilt_valid), 0);
    rst_n = 1;
    tick();

    // R2: unpolluted updates do nothing
    tag = "R2"; policy_sel = 2'd0;
    evict(0, 16'h00FF, 0, 60); tick(); tick();

    // R3 + R7 + R10: every policy, full round trip
    tag = "R3";
    evict(0, 16'h00F3, 1, 2);
    tag = "R10";
    serve(16'h00F2, 16'h00A2);
    tick();

    // R9: bogus, duplicate and idle responses
    tag = "R9";
    respond(9, 1); tick();
    evict(2, 16'h0C04, 1, 1);
    respond(5, 1);          // not pending
    respond(10, 1);         // pending, present
    respond(10, 0);         // duplicate, ignored
    respond(11, 0);         // last -> rebuilt 0x0400
    tick(); tick();

    // R8: evictions during busy are dropped
    tag = "R8";
    evict(1, 16'h0006, 1, 1);
    evict(3, 16'hFFFF, 1, 99);
    evict(4, 16'h00F0, 1, 99);
    serve(16'h0004, 16'h0004);

    // R7: empty target produces nothing
    tag = "R7";
    evict(3, 16'h0008, 1, 99); tick(); tick();

    // R4: every third qualifying eviction
    tag = "R4"; policy_sel = 2'd1;
    evict(0, 16'h0003, 1, 1); tick();
    evict(0, 16'h0003, 0, 1); tick();   // not qualifying
    evict(0, 16'h0003, 1, 1); tick();
    evict(0, 16'h0003, 1, 1);           // third -> request
    evict(0, 16'h0005, 1, 1);           // busy, no advance
    serve(16'h0002, 16'h0000);
    evict(0, 16'h0003, 1, 1); tick();
    evict(0, 16'h0003, 1, 1); tick();
    evict(1, 16'h0103, 1, 1);           // sixth -> request
    serve(16'h0101, 16'h0100);

    // R5: reference count threshold
    tag = "R5"; policy_sel = 2'd2;
    evict(0, 16'h0011, 1, 47); tick();
    evict(0, 16'h0011, 1, 48);
    serve(16'h0010, 16'h0010);
    evict(0, 16'h0011, 1, 200);
    serve(16'h0010, 16'h0000);

    // R6: sharer count threshold
    tag = "R6"; policy_sel = 2'd3;
    evict(0, 16'h000F, 1, 1); tick();
    evict(0, 16'h001F, 1, 1);
    serve(16'h001E, 16'h0014);
    evict(7, 16'hF0F0, 1, 1);
    serve(16'hF070, 16'hF070);

    repeat (3) tick();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule